// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block holds the interrupt logic for a bank of GPIO pins. Each pad input goes through a two-stage synchronizer. A detector then compares the current sample with the one before it, so it can catch a level or an edge. The pin's configuration register selects which. A detected event sets a sticky per-pin status bit. Software clears that bit by writing to it over a simple register port. The status bit, gated by the pin's enable, is routed by a 3-bit target field to one of several summary interrupt outputs.

The detection field comes in two build-time variants. The 2-bit variant offers level, rising, falling and true both-edge detection. The 1-bit variant chooses only between level and edge, and the polarity bit alone sets the edge direction. A per-pin build parameter sets whether writing 1 or writing 0 clears a status bit. The register port is plain: a write strobe with address and data, and a combinational read. There is no stream traffic, so no valid/ready handshake and no back-pressure apply.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every configuration register, every status bit and every `irq_o` bit is 0.
- R2: A pad change reaches the status bit on the third rising clock edge after the pad changes. Two synchronizer stages come first, then the status register.
- R3: With DET_W=2, the detection field is config bits [3:2]. Code 0 is level, 1 is rising edge, 2 is falling edge and 3 is both edges. The edge codes detect only when the polarity bit (bit 4) is 1. With polarity 0 an edge code detects nothing.
- R4: In level detection, polarity 1 is active-high and polarity 0 is active-low. While the level stays active, the status bit sets again after a clear.
- R5: With DET_W=1, only config bit 2 is used for detection: 0 is level and 1 is edge. In edge mode, polarity 1 catches only rising edges and polarity 0 catches only falling edges. Code 3 in bits [3:2] gives rising-only detection and never both edges.
- R6: A status bit stays set until it is cleared, even after the pad returns to its idle value.
- R7: A status write clears bit 0 only when the written bit 0 equals that pin's ACK_HIGH bit. Writing the opposite value leaves the status unchanged.
- R8: When a new event arrives in the same cycle as a clear, the status stays set.
- R9: The enable bit (config bit 0) gates the status into `irq_o`. Status capture still happens while enable is 0.
- R10: A configuration write that takes the enable bit from 0 to 1 also clears that pin's pending status in the same cycle.
- R11: Status captures an event only while the raw-status enable (config bit 1) is 1. Changing the raw-status enable while the pad is steady never sets the status.
- R12: `irq_o[t]` is the OR of status AND enable over all pins whose target field (bits [7:5]) equals t. A pin whose target is NUM_TGT or above drives no output.
- R13: Address 2p is the configuration register of pin p and address 2p+1 is its status register, with the status in bit 0. The configuration register reads back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_i | input | NPINS | Asynchronous pad inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | 8 | Combinational read data |
| irq_o | output | NUM_TGT | Summary interrupt per target |

## Verification
The bench builds two copies with four pins and four targets. The first copy uses 2-bit detection and alternating clear polarities (ACK_HIGH=0101). It covers rising, falling, both-edge and level modes, edge codes with polarity 0, and an unrouted target 5. The second copy uses 1-bit detection with ACK_HIGH=0011. It shows that the polarity alone picks the edge and that code 3 cannot catch both edges. Together the two copies exercise both clear values in both variants.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_W = 8;
  localparam int TGT_W = 3;

  // Configuration word, MSB first: target, polarity, detect, raw enable, enable
  typedef struct packed {
    logic [TGT_W-1:0] tgt;
    logic             pol;
    logic [1:0]       det;
    logic             raw;
    logic             en;
  } irq_cfg_t;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prv_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_o  <= '0;
      prv_o  <= '0;
    end else begin
      meta_q <= pad_i;
      cur_o  <= meta_q;
      prv_o  <= cur_o;
    end
  end
endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
#(
  parameter int   DET_W  = 2,
  parameter logic ACK_HI = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cur,
  input  logic             prv,
  input  logic             cfg_we,
  input  logic             sts_we,
  input  logic [REG_W-1:0] wdata,
  output irq_cfg_t         cfg_q,
  output logic             sts_q
);
  logic rise, fall, lvl, hit, ack_hit, unmask, clr;

  assign rise = cur & ~prv;
  assign fall = ~cur & prv;
  assign lvl  = (cur == cfg_q.pol);

  generate
    if (DET_W == 2) begin : g_w2
      always_comb begin
        case (cfg_q.det)
          2'd0:    hit = lvl;
          2'd1:    hit = cfg_q.pol & rise;
          2'd2:    hit = cfg_q.pol & fall;
          default: hit = cfg_q.pol & (rise | fall);
        endcase
      end
    end else begin : g_w1
      always_comb hit = cfg_q.det[0] ? (cfg_q.pol ? rise : fall) : lvl;
    end
  endgenerate

  assign ack_hit = sts_we & (wdata[0] == ACK_HI);
  assign unmask  = cfg_we & wdata[0] & ~cfg_q.en;
  assign clr     = ack_hit | unmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      sts_q <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= irq_cfg_t'(wdata);
      // a fresh event outranks a clear in the same cycle
      sts_q <= (cfg_q.raw & hit) | (sts_q & ~clr);
    end
  end
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
  import gpio_irq_pkg::*;
#(
  parameter int NPINS   = 4,
  parameter int NUM_TGT = 4
) (
  input  logic [NPINS-1:0]       act,
  input  logic [NPINS*TGT_W-1:0] tgt,
  output logic [NUM_TGT-1:0]     irq_o
);
  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    logic any;
    always_comb begin
      any = 1'b0;
      for (int p = 0; p < NPINS; p++)
        if (act[p] && (tgt[p*TGT_W +: TGT_W] == TGT_W'(t))) any = 1'b1;
    end
    assign irq_o[t] = any;
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int               NPINS    = 4,
  parameter int               NUM_TGT  = 4,
  parameter int               DET_W    = 2,
  parameter logic [NPINS-1:0] ACK_HIGH = '1,
  localparam int              AW       = $clog2(2 * NPINS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   pad_i,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [AW-1:0]      rd_addr,
  output logic [REG_W-1:0]   rd_data,
  output logic [NUM_TGT-1:0] irq_o
);
  logic [NPINS-1:0]       cur, prv;
  logic [NPINS-1:0]       sts_vec, en_vec, raw_vec;
  logic [NPINS*TGT_W-1:0] tgt_flat;
  irq_cfg_t               cfg_arr [NPINS];

  gpio_irq_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_i(pad_i), .cur_o(cur), .prv_o(prv)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic hit_pin;
    assign hit_pin = wr_en && (wr_addr[AW-1:1] == (AW-1)'(p));

    gpio_irq_pin #(.DET_W(DET_W), .ACK_HI(ACK_HIGH[p])) u_pin (
      .clk(clk), .rst_n(rst_n), .cur(cur[p]), .prv(prv[p]),
      .cfg_we(hit_pin & ~wr_addr[0]), .sts_we(hit_pin & wr_addr[0]),
      .wdata(wr_data), .cfg_q(cfg_arr[p]), .sts_q(sts_vec[p])
    );

    assign en_vec[p]                   = cfg_arr[p].en;
    assign raw_vec[p]                  = cfg_arr[p].raw;
    assign tgt_flat[p*TGT_W +: TGT_W]  = cfg_arr[p].tgt;
  end

  gpio_irq_route #(.NPINS(NPINS), .NUM_TGT(NUM_TGT)) u_route (
    .act(sts_vec & en_vec), .tgt(tgt_flat), .irq_o(irq_o)
  );

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NPINS; p++)
      if (rd_addr[AW-1:1] == (AW-1)'(p))
        rd_data = rd_addr[0] ? {{(REG_W-1){1'b0}}, sts_vec[p]} : REG_W'(cfg_arr[p]);
  end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int NPINS   = 4,
  parameter int NUM_TGT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [NUM_TGT-1:0] irq_o,
  input logic [NPINS-1:0]   sts_vec,
  input logic [NPINS-1:0]   en_vec,
  input logic [NPINS-1:0]   raw_vec
);
  // R6
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((~sts_vec & $past(sts_vec)) == '0));

  // R9
  gated_by_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec == '0) |-> (irq_o == '0));

  // R12
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o != '0) |-> ((sts_vec & en_vec) != '0));

  // R11
  no_capture_raw_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_vec == '0) |=> ((sts_vec & ~$past(sts_vec)) == '0));
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPINS(NPINS), .NUM_TGT(NUM_TGT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .irq_o(irq_o),
  .sts_vec(sts_vec), .en_vec(en_vec), .raw_vec(raw_vec)
);

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [3:0] pad  [2];
  logic       wen  [2];
  logic [2:0] wad  [2];
  logic [7:0] wdt  [2];
  logic [2:0] rad  [2];
  logic [7:0] rdt  [2];
  logic [3:0] irqv [2];

  gpio_irq_detect #(.NPINS(4), .NUM_TGT(4), .DET_W(2), .ACK_HIGH(4'b0101)) u_dut (
    .clk(clk), .rst_n(rst_n), .pad_i(pad[0]), .wr_en(wen[0]), .wr_addr(wad[0]),
    .wr_data(wdt[0]), .rd_addr(rad[0]), .rd_data(rdt[0]), .irq_o(irqv[0]));

  gpio_irq_detect #(.NPINS(4), .NUM_TGT(4), .DET_W(1), .ACK_HIGH(4'b0011)) u_dut1 (
    .clk(clk), .rst_n(rst_n), .pad_i(pad[1]), .wr_en(wen[1]), .wr_addr(wad[1]),
    .wr_data(wdt[1]), .rd_addr(rad[1]), .rd_data(rdt[1]), .irq_o(irqv[1]));

  typedef struct {
    int         d;
    logic [7:0] rd;
    logic [3:0] irq;
    string      tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (rdt[it.d] !== it.rd || irqv[it.d] !== it.irq) begin
        n_bad++;
        $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b",
                 it.tag, rdt[it.d], irqv[it.d], it.rd, it.irq);
      end
    end
  end

  task automatic exp(int d, int a, logic [7:0] rd, logic [3:0] irq, string tag);
    @(negedge clk);
    rad[d] = 3'(a);
    q.push_back('{d, rd, irq, tag});
  endtask

  task automatic wreg(int d, int a, logic [7:0] v);
    @(negedge clk);
    wen[d] = 1'b1; wad[d] = 3'(a); wdt[d] = v;
    @(negedge clk);
    wen[d] = 1'b0;
  endtask

  task automatic drive_pad(int d, int p, logic v);
    @(negedge clk);
    pad[d][p] = v;
  endtask

  task automatic setpad(int d, int p, logic v);
    drive_pad(d, p, v);
    repeat (2) @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      pad[d] = '0; wen[d] = 1'b0; wad[d] = '0; wdt[d] = '0; rad[d] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    exp(0, 0, 8'h00, 4'b0000, "R1 cfg0 reset");
    exp(0, 1, 8'h00, 4'b0000, "R1 sts0 reset");
    exp(1, 1, 8'h00, 4'b0000, "R1 dut1 sts0 reset");

    // 2-bit mode, pin0 rising, tgt0, ack high
    wreg(0, 0, 8'h17);
    exp(0, 0, 8'h17, 4'b0000, "R13 cfg readback");
    drive_pad(0, 0, 1'b1);
    exp(0, 1, 8'h00, 4'b0000, "R2 edge1 not yet");
    exp(0, 1, 8'h00, 4'b0000, "R2 edge2 not yet");
    exp(0, 1, 8'h01, 4'b0001, "R2 R3 rise captured");
    setpad(0, 0, 1'b0);
    exp(0, 1, 8'h01, 4'b0001, "R6 sticky after pad idle");
    wreg(0, 1, 8'h00);
    exp(0, 1, 8'h01, 4'b0001, "R7 wrong ack value ignored");
    wreg(0, 1, 8'h01);
    exp(0, 1, 8'h00, 4'b0000, "R7 ack high clears");
    setpad(0, 0, 1'b1);
    wreg(0, 1, 8'h01);
    setpad(0, 0, 1'b0);
    exp(0, 1, 8'h00, 4'b0000, "R3 rising ignores fall");

    // pin1 falling, tgt1, ack low
    wreg(0, 2, 8'h3B);
    setpad(0, 1, 1'b1);
    exp(0, 3, 8'h00, 4'b0000, "R3 falling ignores rise");
    setpad(0, 1, 1'b0);
    exp(0, 3, 8'h01, 4'b0010, "R3 fall captured tgt1");
    wreg(0, 3, 8'h01);
    exp(0, 3, 8'h01, 4'b0010, "R7 ack low ignores 1");
    wreg(0, 3, 8'h00);
    exp(0, 3, 8'h00, 4'b0000, "R7 ack low clears");

    // pin2 both edges, tgt2
    wreg(0, 4, 8'h5F);
    setpad(0, 2, 1'b1);
    exp(0, 5, 8'h01, 4'b0100, "R3 both rise");
    wreg(0, 5, 8'h01);
    exp(0, 5, 8'h00, 4'b0000, "R7 clear pin2");
    setpad(0, 2, 1'b0);
    exp(0, 5, 8'h01, 4'b0100, "R3 both fall");
    wreg(0, 5, 8'h01);
    wreg(0, 4, 8'h4F);
    exp(0, 4, 8'h4F, 4'b0000, "R13 cfg readback pol0");
    setpad(0, 2, 1'b1);
    exp(0, 5, 8'h00, 4'b0000, "R3 edge with pol0 silent");

    // pin3 level, tgt3
    wreg(0, 6, 8'h73);
    setpad(0, 3, 1'b1);
    exp(0, 7, 8'h01, 4'b1000, "R4 level high");
    wreg(0, 7, 8'h00);
    exp(0, 7, 8'h01, 4'b1000, "R4 R8 level resets over clear");
    wreg(0, 6, 8'h63);
    wreg(0, 7, 8'h00);
    exp(0, 7, 8'h00, 4'b0000, "R4 active-low idle while high");
    setpad(0, 3, 1'b0);
    exp(0, 7, 8'h01, 4'b1000, "R4 level low");
    wreg(0, 6, 8'h00);
    wreg(0, 7, 8'h00);
    exp(0, 7, 8'h00, 4'b0000, "R4 pin3 quiet");

    // enable gating and unmask clear on pin0
    wreg(0, 0, 8'h16);
    setpad(0, 0, 1'b1);
    exp(0, 1, 8'h01, 4'b0000, "R9 captured but gated");
    wreg(0, 0, 8'h17);
    exp(0, 1, 8'h00, 4'b0000, "R10 unmask clears stale");

    // raw-status enable
    wreg(0, 0, 8'h15);
    setpad(0, 0, 1'b0);
    setpad(0, 0, 1'b1);
    exp(0, 1, 8'h00, 4'b0000, "R11 raw off blocks capture");
    wreg(0, 0, 8'h17);
    exp(0, 1, 8'h00, 4'b0000, "R11 raw on no false set");
    wreg(0, 0, 8'h15);
    wreg(0, 0, 8'h17);
    exp(0, 1, 8'h00, 4'b0000, "R11 raw toggle no false set");

    // routing
    wreg(0, 2, 8'hB3);
    setpad(0, 1, 1'b1);
    exp(0, 3, 8'h01, 4'b0000, "R12 target 5 unrouted");
    wreg(0, 2, 8'h13);
    exp(0, 3, 8'h01, 4'b0001, "R12 pin1 to tgt0");
    setpad(0, 0, 1'b0);
    setpad(0, 0, 1'b1);
    exp(0, 1, 8'h01, 4'b0001, "R12 two pins share tgt0");
    wreg(0, 2, 8'h00);
    exp(0, 3, 8'h01, 4'b0001, "R12 pin0 alone keeps tgt0");

    // 1-bit mode copy
    wreg(1, 0, 8'h17);
    setpad(1, 0, 1'b1);
    exp(1, 1, 8'h01, 4'b0001, "R5 pol1 rise");
    wreg(1, 1, 8'h01);
    exp(1, 1, 8'h00, 4'b0000, "R7 dut1 ack high");
    setpad(1, 0, 1'b0);
    exp(1, 1, 8'h00, 4'b0000, "R5 pol1 ignores fall");
    wreg(1, 2, 8'h27);
    setpad(1, 1, 1'b1);
    exp(1, 3, 8'h00, 4'b0000, "R5 pol0 ignores rise");
    setpad(1, 1, 1'b0);
    exp(1, 3, 8'h01, 4'b0010, "R5 pol0 fall");
    wreg(1, 3, 8'h00);
    exp(1, 3, 8'h01, 4'b0010, "R7 dut1 wrong ack");
    wreg(1, 3, 8'h01);
    exp(1, 3, 8'h00, 4'b0000, "R7 dut1 ack clears");
    wreg(1, 4, 8'h5F);
    setpad(1, 2, 1'b1);
    exp(1, 5, 8'h01, 4'b0100, "R5 code3 rise");
    wreg(1, 5, 8'h00);
    exp(1, 5, 8'h00, 4'b0000, "R7 dut1 ack low clears");
    setpad(1, 2, 1'b0);
    exp(1, 5, 8'h00, 4'b0000, "R5 no both-edge in 1-bit");
    wreg(1, 6, 8'h73);
    setpad(1, 3, 1'b1);
    exp(1, 7, 8'h01, 4'b1000, "R5 level in 1-bit");

    repeat (3) @(negedge clk);
    done = 1;
    report();
  end
endmodule